// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Timer

This block sits beside a MAC transmitter and decides the cycles in which a new frame may begin. It times the inter-frame gap after the MAC's own frame using a back-to-back count. In half-duplex operation it also follows the PHY carrier-sense line. While carrier is present it holds transmission off. When carrier drops, it times a separate two-part gap.

The gap after carrier is split into part 1 and part 2. When the split option is on, carrier seen during part 1 throws the timer back into deferral. Carrier seen during part 2 is disregarded, so a station that has passed the first stretch keeps its place. When the option is off, carrier anywhere in the gap restarts it. All counts advance on a byte-time strobe. Carrier sense has no effect in full duplex. It also has no effect at gigabit speed, where half duplex is not supported and a half-duplex setting is taken as full duplex.

Top module: `tx_defer_timer`

## Requirements
- R1: After reset, with carrier low, `txPermit` is 1 and `txGrant` is 0 while `txReq` is 0.
- R2: A one-cycle `txDone` pulse holds `txPermit` low for exactly `b2bGap` clock cycles after the edge that samples it, with `byteTick` high every cycle.
- R3: In half duplex (`fullDuplex`=0, `gigSpeed`=0), `txPermit` is 0 in every cycle in which `crs` is 1.
- R4: In half duplex, after `crs` is first sampled low following a carrier event, `txPermit` stays low for `nb1Gap`+`nb2Gap` byte ticks and then rises.
- R5: With `splitEn`=1, carrier sampled during part 1 restarts deferral. `txPermit` rises `nb1Gap`+`nb2Gap` ticks after the edge that next samples `crs` low.
- R6: With `splitEn`=1, carrier during part 2 has no effect. `txPermit` rises at the originally scheduled cycle if `crs` has fallen by then.
- R7: With `splitEn`=0, carrier sampled during part 2 also restarts deferral and the whole two-part gap.
- R8: In full duplex (`fullDuplex`=1), `crs` has no effect on `txPermit` or on any gap length.
- R9: Half duplex requested at gigabit speed (`gigSpeed`=1) behaves as full duplex: `crs` is ignored.
- R10: `txGrant` is 1 exactly when `txReq` and `txPermit` are both 1. A request held through a gap is granted in the first cycle that `txPermit` returns.
- R11: Gap counters advance only in cycles with `byteTick`=1. With the strobe held low, a gap never ends.
- R12: `txDone` takes priority in every state. It restarts a back-to-back gap even during deferral, a carrier gap or a running back-to-back gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteTick | input | 1 | One pulse per byte time; gap counters advance on it |
| txReq | input | 1 | MAC wishes to start a frame |
| txDone | input | 1 | One-cycle pulse at the end of the MAC's own frame |
| crs | input | 1 | PHY carrier sense |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| gigSpeed | input | 1 | 1 = gigabit link (forces full-duplex handling) |
| splitEn | input | 1 | 1 = carrier ignored in part 2 of the carrier gap |
| b2bGap | input | CNT_W | Back-to-back gap length in byte times (at least 1) |
| nb1Gap | input | CNT_W | Part 1 of the carrier gap in byte times (at least 1) |
| nb2Gap | input | CNT_W | Part 2 of the carrier gap in byte times (at least 1) |
| txPermit | output | 1 | No gap or deferral active; a frame may start |
| txGrant | output | 1 | Request accepted this cycle |

## Verification
The assertions assume that every gap count is at least 1 and does not change while a gap that uses it is running. They also assume `txDone` is a single-cycle pulse and that the duplex and speed inputs change only while the block is idle. The stimulus programs counts between 1 and 8 and changes them only between measurements, after `txPermit` has returned. It also drives `txDone` for exactly one cycle and switches mode only with carrier low and the timer idle.

// File: rtl/tx_defer_pkg.sv
package tx_defer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_B2B,
    ST_DEFER,
    ST_NB1,
    ST_NB2
  } deferState_e;

  typedef enum logic [1:0] {
    SEL_B2B,
    SEL_NB1,
    SEL_NB2
  } gapSel_e;

  // strobes from control to the gap counter
  typedef struct packed {
    logic    clr;
    logic    inc;
    gapSel_e sel;
  } cntCtrl_t;

endpackage

// File: rtl/tx_defer_dp.sv
module tx_defer_dp
  import tx_defer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_t         ctl,
  input  logic [CNT_W-1:0] b2bGap,
  input  logic [CNT_W-1:0] nb1Gap,
  input  logic [CNT_W-1:0] nb2Gap,
  output logic             cntLast
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  always_comb begin
    case (ctl.sel)
      SEL_NB1: limit = nb1Gap;
      SEL_NB2: limit = nb2Gap;
      default: limit = b2bGap;
    endcase
  end

  assign cntLast = (count == limit - ONE);

  always_ff @(posedge clk) begin
    if (!rstN)        count <= '0;
    else if (ctl.clr) count <= '0;
    else if (ctl.inc) count <= count + ONE;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inc && !ctl.clr) |-> (count < limit)); // R11

endmodule

// File: rtl/tx_defer_ctrl.sv
module tx_defer_ctrl
  import tx_defer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     byteTick,
  input  logic     txDone,
  input  logic     crs,
  input  logic     fullDuplex,
  input  logic     gigSpeed,
  input  logic     splitEn,
  input  logic     cntLast,
  output cntCtrl_t ctl,
  output logic     txPermit
);

  deferState_e state, nxtState;
  logic halfDup, crsEff, step;

  assign halfDup = !fullDuplex && !gigSpeed;  // gigabit never defers
  assign crsEff  = crs && halfDup;
  assign step    = byteTick && cntLast;

  always_comb begin
    nxtState = state;
    case (state)
      ST_IDLE:  if (crsEff) nxtState = ST_DEFER;
      ST_B2B:   if (step) nxtState = ST_IDLE;
      ST_DEFER: if (!crsEff) nxtState = ST_NB1;
      ST_NB1: begin
        if (crsEff)    nxtState = ST_DEFER;
        else if (step) nxtState = ST_NB2;
      end
      ST_NB2: begin
        if (crsEff && !splitEn) nxtState = ST_DEFER;
        else if (step)          nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
    if (txDone) nxtState = ST_B2B;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    ctl.clr = txDone || (nxtState != state);
    ctl.inc = byteTick && (state == ST_B2B || state == ST_NB1 || state == ST_NB2);
    case (state)
      ST_NB1:  ctl.sel = SEL_NB1;
      ST_NB2:  ctl.sel = SEL_NB2;
      default: ctl.sel = SEL_B2B;
    endcase
  end

  assign txPermit = (state == ST_IDLE) && !crsEff;

  AST_DONE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txPermit); // R2

  AST_CARRIER_GAP_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEFER && halfDup && !crs) |=> !txPermit); // R4

  AST_PART2_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NB2 && splitEn && !txDone && !cntLast) |=> (state == ST_NB2)); // R6

  AST_FD_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!halfDup && state == ST_IDLE && !txDone) |=> (state == ST_IDLE)); // R8

endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer
  import tx_defer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteTick,
  input  logic             txReq,
  input  logic             txDone,
  input  logic             crs,
  input  logic             fullDuplex,
  input  logic             gigSpeed,
  input  logic             splitEn,
  input  logic [CNT_W-1:0] b2bGap,
  input  logic [CNT_W-1:0] nb1Gap,
  input  logic [CNT_W-1:0] nb2Gap,
  output logic             txPermit,
  output logic             txGrant
);

  cntCtrl_t ctl;
  logic     cntLast;

  tx_defer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteTick(byteTick), .txDone(txDone),
    .crs(crs), .fullDuplex(fullDuplex), .gigSpeed(gigSpeed),
    .splitEn(splitEn), .cntLast(cntLast), .ctl(ctl), .txPermit(txPermit)
  );

  tx_defer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .b2bGap(b2bGap),
    .nb1Gap(nb1Gap), .nb2Gap(nb2Gap), .cntLast(cntLast)
  );

  assign txGrant = txReq && txPermit;

endmodule

// File: tb/tx_defer_timer_bench.sv
module tx_defer_timer_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, byteTick, txReq, txDone, crs, fullDuplex, gigSpeed, splitEn;
  logic [7:0] b2bGap, nb1Gap, nb2Gap;
  logic txPermit, txGrant;

  int nChecks = 0;
  int nFail = 0;

  tx_defer_timer u_tx_defer_timer (
    .clk(clk), .rstN(rstN), .byteTick(byteTick), .txReq(txReq), .txDone(txDone),
    .crs(crs), .fullDuplex(fullDuplex), .gigSpeed(gigSpeed), .splitEn(splitEn),
    .b2bGap(b2bGap), .nb1Gap(nb1Gap), .nb2Gap(nb2Gap),
    .txPermit(txPermit), .txGrant(txGrant)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // count cycles with permit low, sampling at falling edges
  task automatic lowRun(output int n);
    n = 0;
    while (!txPermit && n < 500) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulseDone();
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  // carrier for len cycles; returns at the first sample after loss is seen
  task automatic carrier(input int len);
    crs = 1'b1;
    repeat (len) @(negedge clk);
    crs = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n, bad;
    rstN = 0; byteTick = 1; txReq = 0; txDone = 0; crs = 0;
    fullDuplex = 0; gigSpeed = 0; splitEn = 1;
    b2bGap = 3; nb1Gap = 2; nb2Gap = 2;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    check(txPermit == 1 && txGrant == 0, "R1", {txPermit, txGrant}, 2);

    // R2 back-to-back gap sweep
    for (int g = 1; g <= 8; g++) begin
      b2bGap = 8'(g);
      pulseDone();
      lowRun(n);
      check(n == g, "R2", n, g);
    end

    // R3 carrier holds off, R4 two-part gap sweep
    for (int p1 = 1; p1 <= 4; p1++) begin
      for (int p2 = 1; p2 <= 4; p2++) begin
        nb1Gap = 8'(p1); nb2Gap = 8'(p2);
        crs = 1;
        @(negedge clk);
        check(!txPermit, "R3", txPermit, 0);
        crs = 0;
        @(negedge clk);
        lowRun(n);
        check(n == p1 + p2, "R4", n, p1 + p2);
      end
    end

    // R5 carrier in part 1 restarts
    nb1Gap = 4; nb2Gap = 3; splitEn = 1;
    carrier(2);
    repeat (2) @(negedge clk);
    crs = 1;
    @(negedge clk);
    crs = 0;
    lowRun(n);
    check(n == 8, "R5", n, 8);

    // R6 carrier in part 2 ignored
    nb1Gap = 3; nb2Gap = 4; splitEn = 1;
    carrier(2);
    repeat (4) @(negedge clk);
    crs = 1;
    @(negedge clk);
    crs = 0;
    lowRun(n);
    check(n == 2, "R6", n, 2);

    // R7 no split: carrier in part 2 restarts everything
    splitEn = 0;
    carrier(2);
    repeat (4) @(negedge clk);
    crs = 1;
    @(negedge clk);
    crs = 0;
    lowRun(n);
    check(n == 8, "R7", n, 8);
    splitEn = 1;

    // R8 full duplex ignores carrier
    fullDuplex = 1; b2bGap = 4;
    crs = 1; bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (!txPermit) bad++;
    end
    check(bad == 0, "R8", bad, 0);
    pulseDone();
    lowRun(n);
    check(n == 4, "R8", n, 4);
    crs = 0; fullDuplex = 0;
    @(negedge clk);

    // R9 gigabit treated as full duplex
    gigSpeed = 1; b2bGap = 5;
    crs = 1; bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (!txPermit) bad++;
    end
    check(bad == 0, "R9", bad, 0);
    pulseDone();
    lowRun(n);
    check(n == 5, "R9", n, 5);
    crs = 0; gigSpeed = 0;
    @(negedge clk);

    // R10 request held through a gap
    b2bGap = 5; txReq = 1;
    @(negedge clk);
    check(txGrant == 1, "R10", txGrant, 1);
    pulseDone();
    n = 0; bad = 0;
    while (!txPermit && n < 500) begin
      if (txGrant) bad++;
      n++;
      @(negedge clk);
    end
    check(bad == 0 && n == 5, "R10", n, 5);
    check(txGrant == 1, "R10", txGrant, 1);
    txReq = 0;
    @(negedge clk);
    check(txGrant == 0, "R10", txGrant, 0);

    // R11 counter frozen without byte strobe
    b2bGap = 3; byteTick = 0;
    pulseDone();
    bad = 0;
    repeat (10) begin
      if (txPermit) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R11", bad, 0);
    byteTick = 1;
    lowRun(n);
    check(n == 3, "R11", n, 3);

    // R12 txDone during carrier gap and during a running b2b gap
    nb1Gap = 4; nb2Gap = 4; b2bGap = 2;
    carrier(2);
    @(negedge clk);
    pulseDone();
    lowRun(n);
    check(n == 2, "R12", n, 2);
    b2bGap = 4;
    pulseDone();
    repeat (2) @(negedge clk);
    pulseDone();
    lowRun(n);
    check(n == 4, "R12", n, 4);

    summary();
  end

endmodule